// File: doc/BRIEF.md
# Transmit/Receive Command Chaining Queue

This block sits between a host and a simple packet engine. It accepts transmit and receive commands with their buffer page numbers. It hands each command to the engine in turn and keeps a record of each completion, so the host can issue operations back to back and service their results later. Each direction has its own two-entry command queue and its own two-entry completion queue. A transmit completion also records whether the destination acknowledged the packet.

Configuration bit 6 selects chaining. With the bit at 0 (the state after reset) the block runs in legacy mode. Each direction then holds at most one outstanding item, counting both a pending command and an uncleared completion. With the bit at 1, each direction holds up to two.

Each direction has an engine FSM with three states:
- ENG_IDLE goes to ENG_LAUNCH when a command is queued.
- ENG_LAUNCH drives a one-cycle start and moves on to ENG_RUN.
- ENG_RUN returns to ENG_IDLE on the engine's done pulse, which retires the head command.

Each direction also has a flag FSM with three states:
- FLG_CLEAR goes to FLG_SHOW when a completion is pushed.
- FLG_SHOW goes to FLG_CLEAR on a clear command that empties the completion queue.
- FLG_SHOW goes to FLG_GAP on a clear command that leaves an entry behind.
- FLG_GAP returns to FLG_SHOW after one cycle, so the flag rises again as a fresh edge.

Top module: `cmdchain_queue`

## Requirements
- R1: After reset the status byte is 0x03 (both engines idle, no flags, no overflow, legacy mode), irq is 0 and no start is driven.
- R2: Chaining is active only while cfg_reg bit 6 is 1, and status bit 7 shows it. In legacy mode a direction accepts a command only when it holds no pending command and no uncleared completion, so a second transmit command is dropped and never started.
- R3: Command codes are 0 = enable transmit, 1 = enable receive, 2 = clear transmit interrupt, 3 = clear receive interrupt. An accepted command to an idle engine produces a start pulse exactly one cycle long, two cycles after the command cycle, with the command's page on the page output.
- R4: In chaining mode a second command of a direction is held while the first runs. It starts automatically, with its own page, two cycles after the first completes.
- R5: The transmit flag (status bit 2) is set only by a transmit completion. The receive flag (status bit 4) is set only by a receive completion. Each direction's traffic leaves the other direction's flag unchanged.
- R6: Status bit 3 shows the acknowledged bit of the oldest queued transmit completion, and reads 0 whenever bit 2 is 0.
- R7: A flag falls only after its direction's clear command, which removes the oldest completion. If another completion remains, the flag is low for exactly one cycle and then reads 1 with that entry's status.
- R8: A command that would exceed its direction's limit (pending commands plus uncleared completions) is ignored. It sets a sticky overflow bit (status bit 5 for transmit, bit 6 for receive), and that direction's clear command removes the bit.
- R9: irq is 1 exactly when (bit 2 and int_mask[0]) or (bit 4 and int_mask[1]).
- R10: Status bit 0 (transmit) and bit 1 (receive) read 1 exactly when that direction has no queued or running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_reg | input | 8 | Configuration byte; bit 6 enables chaining |
| cmd_valid | input | 1 | Host command strobe, one cycle per command |
| cmd_op | input | 2 | Command code |
| cmd_page | input | PAGE_W | Buffer page for enable commands |
| int_mask | input | 2 | Bit 0 unmasks the transmit flag, bit 1 the receive flag |
| tx_start | output | 1 | One-cycle transmit start to the engine |
| tx_page | output | PAGE_W | Page of the transmit being started/run |
| tx_done | input | 1 | Transmit completion pulse |
| tx_acked | input | 1 | Destination acknowledged, valid with tx_done |
| rx_start | output | 1 | One-cycle receive start to the engine |
| rx_page | output | PAGE_W | Page of the receive being started/run |
| rx_done | input | 1 | Receive completion pulse |
| status | output | 8 | Status byte |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with PAGE_W = 4 and DEPTH = 2. With these values a full transmit queue takes two commands, so it can be filled, drained and overflowed in a few cycles. Distinct page values show which queued command the engine receives. The two-entry completion queue shows both the one-cycle flag gap and the ack bit of the second entry.

// File: rtl/cmdchain_pkg.sv
package cmdchain_pkg;

    typedef enum logic [1:0] {
        OP_TX_EN  = 2'd0,
        OP_RX_EN  = 2'd1,
        OP_CLR_TX = 2'd2,
        OP_CLR_RX = 2'd3
    } cc_op_e;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_LAUNCH = 2'd1,
        ENG_RUN    = 2'd2
    } eng_state_e;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SHOW  = 2'd1,
        FLG_GAP   = 2'd2
    } flg_state_e;

    localparam int CHAIN_CFG_BIT = 6;
    localparam int SB_TX_IDLE    = 0;
    localparam int SB_RX_IDLE    = 1;
    localparam int SB_TX_FLAG    = 2;
    localparam int SB_TX_ACK     = 3;
    localparam int SB_RX_FLAG    = 4;
    localparam int SB_TX_OVF     = 5;
    localparam int SB_RX_OVF     = 6;
    localparam int SB_CHAIN      = 7;
    localparam int N_DIR         = 2;

endpackage

// File: rtl/cc_fifo.sv
module cc_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [W-1:0]                   din,
    input  logic                           pop,
    output logic [W-1:0]                   dout,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/cc_dir_ctrl.sv
module cc_dir_ctrl
    import cmdchain_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_en,
    input  logic              enq,
    input  logic [PAGE_W-1:0] enq_page,
    input  logic              clr,
    input  logic              eng_done,
    input  logic              eng_ack,
    output logic              eng_start,
    output logic [PAGE_W-1:0] eng_page,
    output logic              idle_live,
    output logic              flag,
    output logic              head_ack,
    output logic              ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int OCC_W = $clog2(2 * DEPTH + 1);

    eng_state_e eng_q, eng_d;
    flg_state_e flg_q, flg_d;

    logic [CNT_W-1:0] cmd_cnt;
    logic [CNT_W-1:0] cpl_cnt;
    logic [OCC_W-1:0] occupancy;
    logic [OCC_W-1:0] limit;
    logic             accept;
    logic             done_evt;
    logic             cpl_pop;
    logic             cpl_dout;
    logic [CNT_W:0]   cpl_left;

    // Admission: commands waiting plus completions not yet cleared.
    assign occupancy = OCC_W'(cmd_cnt) + OCC_W'(cpl_cnt);
    assign limit     = chain_en ? OCC_W'(DEPTH) : OCC_W'(1);
    assign accept    = enq && (occupancy < limit);
    assign done_evt  = (eng_q == ENG_RUN) && eng_done;
    assign cpl_pop   = clr && (flg_q == FLG_SHOW);
    assign cpl_left  = (CNT_W + 1)'(cpl_cnt) + (CNT_W + 1)'(done_evt) - (CNT_W + 1)'(cpl_pop);

    cc_fifo #(.W(PAGE_W), .DEPTH(DEPTH)) u_cmd_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (enq_page),
        .pop   (done_evt),
        .dout  (eng_page),
        .count (cmd_cnt)
    );

    cc_fifo #(.W(1), .DEPTH(DEPTH)) u_cpl_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (done_evt),
        .din   (eng_ack),
        .pop   (cpl_pop),
        .dout  (cpl_dout),
        .count (cpl_cnt)
    );

    // Engine FSM: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= ENG_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    // Engine FSM: next state
    always_comb begin
        eng_d = eng_q;
        unique case (eng_q)
            ENG_IDLE:   if (cmd_cnt != '0) eng_d = ENG_LAUNCH;
            ENG_LAUNCH: eng_d = ENG_RUN;
            ENG_RUN:    if (eng_done) eng_d = ENG_IDLE;
            default:    eng_d = ENG_IDLE;
        endcase
    end

    // Flag FSM: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= FLG_CLEAR;
        end else begin
            flg_q <= flg_d;
        end
    end

    // Flag FSM: next state
    always_comb begin
        flg_d = flg_q;
        unique case (flg_q)
            FLG_CLEAR: if (done_evt) flg_d = FLG_SHOW;
            FLG_SHOW: begin
                if (cpl_pop) begin
                    flg_d = (cpl_left != '0) ? FLG_GAP : FLG_CLEAR;
                end
            end
            FLG_GAP:   flg_d = FLG_SHOW;
            default:   flg_d = FLG_CLEAR;
        endcase
    end

    // Sticky overflow, removed by this direction's clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (enq && !accept) begin
            ovf <= 1'b1;
        end else if (clr) begin
            ovf <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        eng_start = (eng_q == ENG_LAUNCH);
        idle_live = (eng_q == ENG_IDLE) && (cmd_cnt == '0);
        flag      = (flg_q == FLG_SHOW);
        head_ack  = flag && cpl_dout;
    end

endmodule

// File: rtl/cmdchain_queue.sv
module cmdchain_queue
    import cmdchain_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_reg,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic [1:0]        int_mask,
    output logic              tx_start,
    output logic [PAGE_W-1:0] tx_page,
    input  logic              tx_done,
    input  logic              tx_acked,
    output logic              rx_start,
    output logic [PAGE_W-1:0] rx_page,
    input  logic              rx_done,
    output logic [7:0]        status,
    output logic              irq
);
    logic              chain_en;
    cc_op_e            op;
    logic [N_DIR-1:0]  d_enq;
    logic [N_DIR-1:0]  d_clr;
    logic [N_DIR-1:0]  d_done;
    logic [N_DIR-1:0]  d_ack;
    logic [N_DIR-1:0]  d_start;
    logic [N_DIR-1:0]  d_idle;
    logic [N_DIR-1:0]  d_flag;
    logic [N_DIR-1:0]  d_hack;
    logic [N_DIR-1:0]  d_ovf;
    logic [PAGE_W-1:0] d_page [N_DIR];
    logic [6:0]        unused_cfg;
    logic              unused_rx_hack;

    assign chain_en       = cfg_reg[CHAIN_CFG_BIT];
    assign unused_cfg     = {cfg_reg[7], cfg_reg[5:0]};
    assign unused_rx_hack = d_hack[1];
    assign op             = cc_op_e'(cmd_op);

    // Command decode: index 0 is transmit, index 1 is receive
    always_comb begin
        d_enq[0] = cmd_valid && (op == OP_TX_EN);
        d_enq[1] = cmd_valid && (op == OP_RX_EN);
        d_clr[0] = cmd_valid && (op == OP_CLR_TX);
        d_clr[1] = cmd_valid && (op == OP_CLR_RX);
    end

    assign d_done = {rx_done, tx_done};
    assign d_ack  = {1'b0, tx_acked};

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        cc_dir_ctrl #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_dir (
            .clk       (clk),
            .rst_n     (rst_n),
            .chain_en  (chain_en),
            .enq       (d_enq[g]),
            .enq_page  (cmd_page),
            .clr       (d_clr[g]),
            .eng_done  (d_done[g]),
            .eng_ack   (d_ack[g]),
            .eng_start (d_start[g]),
            .eng_page  (d_page[g]),
            .idle_live (d_idle[g]),
            .flag      (d_flag[g]),
            .head_ack  (d_hack[g]),
            .ovf       (d_ovf[g])
        );
    end

    always_comb begin
        tx_start = d_start[0];
        tx_page  = d_page[0];
        rx_start = d_start[1];
        rx_page  = d_page[1];

        status             = '0;
        status[SB_TX_IDLE] = d_idle[0];
        status[SB_RX_IDLE] = d_idle[1];
        status[SB_TX_FLAG] = d_flag[0];
        status[SB_TX_ACK]  = d_hack[0];
        status[SB_RX_FLAG] = d_flag[1];
        status[SB_TX_OVF]  = d_ovf[0];
        status[SB_RX_OVF]  = d_ovf[1];
        status[SB_CHAIN]   = chain_en;

        irq = (d_flag[0] && int_mask[0]) || (d_flag[1] && int_mask[1]);
    end

endmodule

// File: rtl/cmdchain_queue_chk.sv
module cmdchain_queue_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [1:0] int_mask,
    input logic       tx_start,
    input logic       rx_start,
    input logic [6:0] st,
    input logic       irq
);
    assert_tx_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    assert_rx_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !rx_start);

    assert_tx_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !st[0]);

    assert_rx_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |-> !st[1]);

    assert_tx_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st[2]) |-> $past(cmd_valid && cmd_op == 2'd2));

    assert_rx_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st[4]) |-> $past(cmd_valid && cmd_op == 2'd3));

    assert_ack_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st[2] |-> !st[3]);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == 2'b00) |-> !irq);

    assert_tx_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st[5]) |-> $past(cmd_valid && cmd_op == 2'd0));

    assert_rx_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st[6]) |-> $past(cmd_valid && cmd_op == 2'd1));

endmodule

bind cmdchain_queue cmdchain_queue_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .int_mask  (int_mask),
    .tx_start  (tx_start),
    .rx_start  (rx_start),
    .st        (status[6:0]),
    .irq       (irq)
);

// File: tb/tb_cmdchain_queue.sv
module tb_cmdchain_queue;
    localparam int PAGE_W = 4;
    localparam int DEPTH  = 2;

    localparam logic [1:0] C_TX  = 2'd0;
    localparam logic [1:0] C_RX  = 2'd1;
    localparam logic [1:0] C_CTX = 2'd2;
    localparam logic [1:0] C_CRX = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [7:0]        cfg_reg;
    logic              cmd_valid;
    logic [1:0]        cmd_op;
    logic [PAGE_W-1:0] cmd_page;
    logic [1:0]        int_mask;
    logic              tx_start;
    logic [PAGE_W-1:0] tx_page;
    logic              tx_done;
    logic              tx_acked;
    logic              rx_start;
    logic [PAGE_W-1:0] rx_page;
    logic              rx_done;
    logic [7:0]        status;
    logic              irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    cmdchain_queue #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_reg   (cfg_reg),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_page  (cmd_page),
        .int_mask  (int_mask),
        .tx_start  (tx_start),
        .tx_page   (tx_page),
        .tx_done   (tx_done),
        .tx_acked  (tx_acked),
        .rx_start  (rx_start),
        .rx_page   (rx_page),
        .rx_done   (rx_done),
        .status    (status),
        .irq       (irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [1:0] op, input logic [PAGE_W-1:0] pg);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_page  = pg;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_page  = '0;
    endtask

    task automatic tx_finish(input logic ack);
        tx_done  = 1'b1;
        tx_acked = ack;
        @(negedge clk);
        tx_done  = 1'b0;
        tx_acked = 1'b0;
    endtask

    task automatic rx_finish();
        rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status after reset", 32'(status), 32'h03);
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 no start after reset", 32'({tx_start, rx_start}), 0);
    endtask

    task automatic t_legacy_tx();
        cfg_reg  = 8'h00;
        int_mask = 2'b01;
        send(C_TX, 4'd5);
        check("R10 tx idle drops after accept", 32'(status[0]), 0);
        check("R3 no start in accept cycle", 32'(tx_start), 0);
        tick();
        check("R3 start pulse", 32'(tx_start), 1);
        check("R3 start page", 32'(tx_page), 5);
        tick();
        check("R3 start one cycle", 32'(tx_start), 0);
        check("R5 no flag before completion", 32'(status[2]), 0);
        tx_finish(1'b1);
        check("R5 R6 R10 status after acked tx", 32'(status), 32'h0F);
        check("R9 irq with tx unmasked", 32'(irq), 1);
        tick();
        check("R7 flag holds without clear", 32'(status[2]), 1);
        send(C_CTX, 4'd0);
        check("R7 clear removes flag", 32'(status), 32'h03);
        check("R9 irq gone after clear", 32'(irq), 0);
    endtask

    task automatic t_legacy_ovf();
        cfg_reg = 8'h00;
        send(C_TX, 4'd1);
        send(C_TX, 4'd2);
        check("R8 R2 overflow in legacy", 32'(status[5]), 1);
        check("R2 first page starts", 32'(tx_page), 1);
        tick();
        tick();
        tx_finish(1'b0);
        check("R6 nack shows ack 0", 32'(status[3:2]), 32'b01);
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R2 dropped command never starts", 32'(tx_start), 0);
        end
        check("R2 tx idle after single op", 32'(status[0]), 1);
        send(C_CTX, 4'd0);
        check("R8 clear removes overflow", 32'(status), 32'h03);
    endtask

    task automatic t_chain_pair();
        cfg_reg = 8'h40;
        tick();
        check("R2 chain bit shown", 32'(status[7]), 1);
        send(C_TX, 4'd3);
        send(C_TX, 4'd6);
        check("R4 second accepted no overflow", 32'(status[5]), 0);
        check("R4 first start page", 32'({tx_start, tx_page}), 32'h13);
        tick();
        tick();
        tx_finish(1'b0);
        check("R4 R6 first completion flag, ack 0", 32'(status[3:2]), 32'b01);
        check("R10 tx busy with held command", 32'(status[0]), 0);
        tick();
        check("R4 held command auto start", 32'({tx_start, tx_page}), 32'h16);
        tick();
        tx_finish(1'b1);
        check("R6 ack shows oldest entry", 32'(status[3:2]), 32'b01);
        check("R10 tx idle after both", 32'(status[0]), 1);
        send(C_CTX, 4'd0);
        check("R7 flag gap after pop", 32'(status[3:2]), 32'b00);
        tick();
        check("R7 flag back with second ack", 32'(status[3:2]), 32'b11);
        send(C_CTX, 4'd0);
        check("R7 last clear drops flag", 32'(status[2]), 0);
        tick();
        check("R7 flag stays low", 32'(status), 32'h83);
    endtask

    task automatic t_chain_ovf();
        cfg_reg = 8'h40;
        send(C_TX, 4'd7);
        send(C_TX, 4'd8);
        tick();
        tx_finish(1'b1);
        send(C_TX, 4'd9);
        check("R8 overflow at chain limit", 32'(status[5]), 1);
        check("R8 R4 queued page intact", 32'({tx_start, tx_page}), 32'h18);
        tick();
        tx_finish(1'b1);
        send(C_CTX, 4'd0);
        check("R8 clear removes overflow", 32'(status[5]), 0);
        tick();
        send(C_CTX, 4'd0);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R8 dropped command never starts", 32'(tx_start), 0);
        end
        check("R8 state after drain", 32'(status), 32'h83);
    endtask

    task automatic t_interleave();
        cfg_reg  = 8'h40;
        int_mask = 2'b10;
        send(C_RX, 4'd2);
        send(C_TX, 4'd4);
        check("R3 rx start page", 32'({rx_start, rx_page}), 32'h12);
        check("R10 rx busy", 32'(status[1]), 0);
        check("R5 no tx start yet", 32'(tx_start), 0);
        tick();
        check("R3 tx start page", 32'({tx_start, tx_page}), 32'h14);
        tick();
        rx_finish();
        check("R5 rx flag only", 32'({status[4], status[2]}), 32'b10);
        check("R9 irq from rx", 32'(irq), 1);
        check("R10 rx idle again", 32'(status[1]), 1);
        tx_finish(1'b1);
        check("R5 tx flag set", 32'(status[2]), 1);
        int_mask = 2'b00;
        tick();
        check("R9 irq masked", 32'(irq), 0);
        int_mask = 2'b01;
        tick();
        check("R9 irq from tx", 32'(irq), 1);
        send(C_CRX, 4'd0);
        check("R7 R5 rx clear leaves tx flag", 32'({status[4], status[2]}), 32'b01);
        send(C_CTX, 4'd0);
        check("R7 all clear", 32'(status), 32'h83);
        int_mask = 2'b00;
    endtask

    initial begin
        rst_n     = 1'b0;
        cfg_reg   = 8'h00;
        cmd_valid = 1'b0;
        cmd_op    = 2'd0;
        cmd_page  = '0;
        int_mask  = 2'b00;
        tx_done   = 1'b0;
        tx_acked  = 1'b0;
        rx_done   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_legacy_tx();
        t_legacy_ovf();
        t_chain_pair();
        t_chain_ovf();
        t_interleave();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule